// File: doc/BRIEF.md
# Dual-Area Card Strobe Sequencer

This block times one read or write on a card-style bus. The bus is split into two sub-areas, A and B. A single 32-bit control word holds the timing codes for both sub-areas, and an area-select input picks which set applies to the current access. A start pulse, sampled while the block is idle, latches the selected configuration, the access direction and the space type. The block then runs a fixed sequence. It raises an address-valid output. After the setup delay it drives exactly one active-low strobe, either output-enable for a read or write-enable for a write. It keeps that strobe low for the wait time, releases it, holds the address for the hold delay, and finally pulses done.

The timing codes are not linear. The setup and hold codes use one 8-entry table, the extra-wait code uses a 4-entry table, and the base-wait code uses a 16-entry table. Sub-area B reads its base-wait code from the control word. Sub-area A takes its base-wait code from a separate 4-bit input. The space type of the selected sub-area is passed out for decoding outside the block, together with a flag that marks 16-bit spaces.

Top module: `card_strobe_gen`

## Requirements
- R1: While reset is asserted and after its release, `oe_n_o` and `we_n_o` are 1 and `addr_en_o`, `busy_o` and `done_o` are 0.
- R2: The setup time is the number of cycles that `addr_en_o` is high before the strobe goes low. Setup codes 0..7 map to 0,1,2,3,6,9,12,15 cycles. Sub-area A takes its setup code from control bits [14:12] and sub-area B from bits [10:8].
- R3: The hold time is the number of cycles that `addr_en_o` stays high after the strobe returns high. Hold codes use the same 8-entry table as R2. Sub-area A takes its hold code from bits [6:4] and sub-area B from bits [2:0].
- R4: The strobe stays low for base wait plus extra wait cycles, and never for less than one cycle.
- R5: Extra-wait codes 0..3 map to 0,15,30,50 cycles. Sub-area A takes its extra-wait code from bits [23:22] and sub-area B from bits [21:20].
- R6: Base-wait codes 0..15 map to 0,1,2,3,4,5,6,7,8,9,11,13,15,17,21,25 cycles. Sub-area B takes its base-wait code from bits [19:16]. Sub-area A takes it from `base_wait_a_i`.
- R7: `area_b_i`=1 selects sub-area B. A read (`write_i`=0) drives only `oe_n_o` low and a write drives only `we_n_o` low. The two strobes are never low together.
- R8: `space_type_o` carries the low 3 bits of the selected type field, which is bits [31:28] for sub-area A and bits [27:24] for sub-area B. `wide_o` is 1 when that code is odd. Both outputs hold steady while the strobe is low.
- R9: A start pulse while `busy_o` is high has no effect: no second access follows.
- R10: In the cycle after the hold time ends, `addr_en_o` is 0 and `done_o` is 1 for exactly one cycle. `busy_o` is high from the cycle after start through the done cycle.
- R11: Changes to the control word, area select, direction or `base_wait_a_i` after the start pulse do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an access; taken only when idle |
| area_b_i | input | 1 | 1 selects sub-area B, 0 selects sub-area A |
| write_i | input | 1 | 1 for a write (WE strobe), 0 for a read (OE strobe) |
| ctrl_word_i | input | 32 | Timing and type control word for both sub-areas |
| base_wait_a_i | input | 4 | Base-wait code for sub-area A |
| addr_en_o | output | 1 | Address valid |
| oe_n_o | output | 1 | Output-enable strobe, active low |
| we_n_o | output | 1 | Write-enable strobe, active low |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| space_type_o | output | 3 | Space type code of the selected sub-area |
| wide_o | output | 1 | 16-bit space flag |

## Verification
The hardest case to reach from the ports is a disturbance in the middle of an access. A second start pulse, a changed control word, a flipped area select, a flipped direction and a changed base-wait input all arrive while a long access is still running. The driver produces this by launching an access with a 15-cycle setup and a 75-cycle strobe. Two cycles later it pulses start again and drives inverted values on every configuration input. The scoreboard must then still see exactly one access, with the original timings, strobe and type. Sweeping loops walk every table code in both sub-areas, including the zero-setup, zero-hold and one-cycle-minimum strobe boundaries.

// File: rtl/card_strobe_pkg.sv
package card_strobe_pkg;

  localparam int CNT_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] hold;
    logic [2:0]       space;
    logic             wide;
  } access_cfg_t;

  function automatic logic [CNT_W-1:0] edge_cycles(input logic [2:0] code);
    logic [CNT_W-1:0] c;
    c = CNT_W'(code);
    if (code < 3'd4) return c;
    return CNT_W'(3) * (c - CNT_W'(2));
  endfunction

  function automatic logic [CNT_W-1:0] extra_cycles(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(0);
      2'd1:    return CNT_W'(15);
      2'd2:    return CNT_W'(30);
      default: return CNT_W'(50);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] base_cycles(input logic [3:0] code);
    case (code)
      4'd10:   return CNT_W'(11);
      4'd11:   return CNT_W'(13);
      4'd12:   return CNT_W'(15);
      4'd13:   return CNT_W'(17);
      4'd14:   return CNT_W'(21);
      4'd15:   return CNT_W'(25);
      default: return CNT_W'(code);
    endcase
  endfunction

endpackage

// File: rtl/card_strobe_decode.sv
module card_strobe_decode
  import card_strobe_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic [CFG_W-1:0] ctrl_word_i,
  input  logic [3:0]       base_wait_a_i,
  input  logic             area_b_i,
  output access_cfg_t      cfg_o
);

  localparam int N_AREAS = 2;

  access_cfg_t area_cfg [N_AREAS];

  for (genvar g = 0; g < N_AREAS; g++) begin : g_area
    localparam int SETUP_LSB = (g == 0) ? 12 : 8;
    localparam int HOLD_LSB  = (g == 0) ? 4  : 0;
    localparam int EXTRA_LSB = (g == 0) ? 22 : 20;
    localparam int TYPE_LSB  = (g == 0) ? 28 : 24;

    logic [3:0]       base_code;
    logic [CNT_W-1:0] wait_sum;
    logic [3:0]       type_code;

    if (g == 0) begin : g_ext_base
      assign base_code = base_wait_a_i;
    end else begin : g_word_base
      assign base_code = ctrl_word_i[19:16];
    end

    assign type_code = ctrl_word_i[TYPE_LSB +: 4];
    assign wait_sum  = base_cycles(base_code) +
                       extra_cycles(ctrl_word_i[EXTRA_LSB +: 2]);

    assign area_cfg[g].setup  = edge_cycles(ctrl_word_i[SETUP_LSB +: 3]);
    assign area_cfg[g].hold   = edge_cycles(ctrl_word_i[HOLD_LSB +: 3]);
    assign area_cfg[g].active = (wait_sum == '0) ? CNT_W'(1) : wait_sum;
    assign area_cfg[g].space  = type_code[2:0];
    assign area_cfg[g].wide   = type_code[0];
  end

  assign cfg_o = area_b_i ? area_cfg[1] : area_cfg[0];

endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq
  import card_strobe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        write_i,
  input  access_cfg_t cfg_i,
  output logic        addr_en_o,
  output logic        oe_n_o,
  output logic        we_n_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [2:0]  space_o,
  output logic        wide_o
);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  access_cfg_t      cfg_q;
  logic             wr_q, wr_d;
  logic             load;
  logic             addr_en_d, oe_n_d, we_n_d, done_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load = 1'b1;
          if (cfg_i.setup != '0) begin
            state_d = ST_SETUP;
            cnt_d   = cfg_i.setup - CNT_W'(1);
          end else begin
            state_d = ST_STROBE;
            cnt_d   = cfg_i.active - CNT_W'(1);
          end
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_STROBE;
          cnt_d   = cfg_q.active - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_STROBE: begin
        if (cnt_q == '0) begin
          if (cfg_q.hold != '0) begin
            state_d = ST_HOLD;
            cnt_d   = cfg_q.hold - CNT_W'(1);
          end else begin
            state_d = ST_DONE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) state_d = ST_DONE;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // output decode from next state, registered below
  always_comb begin
    wr_d      = load ? write_i : wr_q;
    addr_en_d = (state_d == ST_SETUP) || (state_d == ST_STROBE) ||
                (state_d == ST_HOLD);
    oe_n_d    = !((state_d == ST_STROBE) && !wr_d);
    we_n_d    = !((state_d == ST_STROBE) && wr_d);
    done_d    = (state_d == ST_DONE);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      addr_en_o <= 1'b0;
      oe_n_o    <= 1'b1;
      we_n_o    <= 1'b1;
      done_o    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      addr_en_o <= addr_en_d;
      oe_n_o    <= oe_n_d;
      we_n_o    <= we_n_d;
      done_o    <= done_d;
    end
  end

  // configuration captured at start (clock enable = load)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      wr_q  <= 1'b0;
    end else if (load) begin
      cfg_q <= cfg_i;
      wr_q  <= write_i;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign space_o = cfg_q.space;
  assign wide_o  = cfg_q.wide;

endmodule

// File: rtl/card_strobe_gen.sv
module card_strobe_gen
  import card_strobe_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             area_b_i,
  input  logic             write_i,
  input  logic [CFG_W-1:0] ctrl_word_i,
  input  logic [3:0]       base_wait_a_i,
  output logic             addr_en_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       space_type_o,
  output logic             wide_o
);

  access_cfg_t sel_cfg;

  card_strobe_decode #(.CFG_W(CFG_W)) u_decode (
    .ctrl_word_i   (ctrl_word_i),
    .base_wait_a_i (base_wait_a_i),
    .area_b_i      (area_b_i),
    .cfg_o         (sel_cfg)
  );

  card_strobe_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .write_i   (write_i),
    .cfg_i     (sel_cfg),
    .addr_en_o (addr_en_o),
    .oe_n_o    (oe_n_o),
    .we_n_o    (we_n_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .space_o   (space_type_o),
    .wide_o    (wide_o)
  );

endmodule

// File: rtl/card_strobe_chk.sv
module card_strobe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       addr_en_o,
  input logic       oe_n_o,
  input logic       we_n_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] space_type_o
);

  logic strobe_on;
  assign strobe_on = !oe_n_o || !we_n_o;

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n_o && !we_n_o));

  // R2
  strobe_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> addr_en_o);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!addr_en_o && busy_o));

  // R8
  type_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && $past(strobe_on)) |-> $stable(space_type_o));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);

endmodule

bind card_strobe_gen card_strobe_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .addr_en_o    (addr_en_o),
  .oe_n_o       (oe_n_o),
  .we_n_o       (we_n_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .space_type_o (space_type_o)
);

// File: tb/card_strobe_gen_bench.sv
module card_strobe_gen_bench;

  typedef struct {
    int setup;
    int active;
    int hold;
    int space;
    int wide;
    int is_write;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        area_b_i;
  logic        write_i;
  logic [31:0] ctrl_word_i;
  logic [3:0]  base_wait_a_i;
  logic        addr_en_o, oe_n_o, we_n_o, busy_o, done_o, wide_o;
  logic [2:0]  space_type_o;

  int n_cmp  = 0;
  int n_bad  = 0;
  int n_done = 0;
  int cyc    = 0;
  bit finished = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  card_strobe_gen u_card_strobe_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .area_b_i(area_b_i),
    .write_i(write_i), .ctrl_word_i(ctrl_word_i), .base_wait_a_i(base_wait_a_i),
    .addr_en_o(addr_en_o), .oe_n_o(oe_n_o), .we_n_o(we_n_o), .busy_o(busy_o),
    .done_o(done_o), .space_type_o(space_type_o), .wide_o(wide_o)
  );

  function automatic int t_edge(int c);
    case (c)
      4: return 6;
      5: return 9;
      6: return 12;
      7: return 15;
      default: return c;
    endcase
  endfunction

  function automatic int t_extra(int c);
    case (c)
      1: return 15;
      2: return 30;
      3: return 50;
      default: return 0;
    endcase
  endfunction

  function automatic int t_base(int c);
    case (c)
      10: return 11;
      11: return 13;
      12: return 15;
      13: return 17;
      14: return 21;
      15: return 25;
      default: return c;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(int ty_a, int ty_b, int ex_a, int ex_b,
                                          int base_b, int su_a, int su_b,
                                          int ho_a, int ho_b);
    logic [31:0] w;
    w = '0;
    w[31:28] = 4'(ty_a);
    w[27:24] = 4'(ty_b);
    w[23:22] = 2'(ex_a);
    w[21:20] = 2'(ex_b);
    w[19:16] = 4'(base_b);
    w[14:12] = 3'(su_a);
    w[10:8]  = 3'(su_b);
    w[6:4]   = 3'(ho_a);
    w[2:0]   = 3'(ho_b);
    return w;
  endfunction

  // driver: compute expectation, push, launch, optionally disturb, wait idle
  task automatic run_access(bit b, bit wr, logic [31:0] w, logic [3:0] base_a,
                            bit disturb);
    exp_t e;
    int sum;
    int ty;
    e.setup  = t_edge(b ? int'(w[10:8]) : int'(w[14:12]));
    e.hold   = t_edge(b ? int'(w[2:0])  : int'(w[6:4]));
    sum      = t_base(b ? int'(w[19:16]) : int'(base_a)) +
               t_extra(b ? int'(w[21:20]) : int'(w[23:22]));
    e.active = (sum == 0) ? 1 : sum;
    ty       = b ? int'(w[27:24]) : int'(w[31:28]);
    e.space  = ty % 8;
    e.wide   = ty % 2;
    e.is_write = wr;
    exp_q.push_back(e);
    @(negedge clk);
    area_b_i = b; write_i = wr; ctrl_word_i = w; base_wait_a_i = base_a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      @(negedge clk);
      // R9 / R11: restart attempt with every input changed mid-access
      start_i = 1'b1; ctrl_word_i = ~w; area_b_i = !b; write_i = !wr;
      base_wait_a_i = ~base_a;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
  endtask

  // monitor / scoreboard
  int  m_s = 0, m_a = 0, m_h = 0;
  bit  m_seen = 0, m_oe = 0, m_we = 0;
  int  m_space = 0, m_wide = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!oe_n_o && !we_n_o) check("R7 both strobes low", 1, 0);
      if (addr_en_o && oe_n_o && we_n_o && !m_seen) m_s++;
      if (!oe_n_o || !we_n_o) begin
        m_seen = 1; m_a++;
        if (!oe_n_o) m_oe = 1;
        if (!we_n_o) m_we = 1;
        m_space = space_type_o; m_wide = wide_o;
      end
      if (addr_en_o && oe_n_o && we_n_o && m_seen) m_h++;
      if (done_o) begin
        n_done++;
        check("R10 address released at done", addr_en_o, 0);
        if (exp_q.size() == 0) begin
          check("R9 unexpected extra access", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R2 setup cycles", m_s, e.setup);
          check("R4 R5 R6 strobe cycles", m_a, e.active);
          check("R3 hold cycles", m_h, e.hold);
          check("R7 oe used for read", m_oe, !e.is_write);
          check("R7 we used for write", m_we, e.is_write);
          check("R8 space type", m_space, e.space);
          check("R8 wide flag", m_wide, e.wide);
        end
        m_s = 0; m_a = 0; m_h = 0; m_seen = 0; m_oe = 0; m_we = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; area_b_i = 1'b0; write_i = 1'b0;
    ctrl_word_i = '0; base_wait_a_i = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1 oe_n in reset", oe_n_o, 1);
    check("R1 we_n in reset", we_n_o, 1);
    check("R1 addr_en in reset", addr_en_o, 0);
    check("R1 busy in reset", busy_o, 0);
    check("R1 done in reset", done_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", {addr_en_o, busy_o, done_o, oe_n_o, we_n_o}, 5'b00011);

    // R4 minimum one cycle: all zero timings, area A read
    run_access(0, 0, mk_word(0, 0, 0, 0, 0, 0, 0, 0, 0), 4'd0, 0);
    // long write on area A with disturbance (R9, R11)
    run_access(0, 1, mk_word(5, 2, 3, 0, 0, 7, 1, 4, 1), 4'd15, 1);
    // area B read, odd type (R8 wide)
    run_access(1, 0, mk_word(2, 7, 3, 1, 10, 0, 5, 0, 2), 4'd3, 0);
    // area B with zero totals: minimum strobe (R4), A fields nonzero to show selection (R7)
    run_access(1, 1, mk_word(1, 6, 3, 0, 0, 7, 0, 7, 0), 4'd15, 0);
    // sweep tables on area B (R2 R3 R5 R6)
    for (int k = 0; k < 8; k++)
      run_access(1, k[0], mk_word(7 - k, k, 3 - (k % 4), k % 4, 2 * k + 1,
                                  7 - k, k, k, 7 - k), 4'(15 - k), 0);
    // sweep tables on area A with external base code (R6)
    for (int k = 0; k < 8; k++)
      run_access(0, !k[0], mk_word(k, 7 - k, k % 4, 3 - (k % 4), 15 - k,
                                   k, 7 - k, 7 - k, k), 4'(2 * k), 0);
    // start pulse arriving during a second long access (R9)
    run_access(1, 0, mk_word(0, 3, 0, 2, 14, 0, 6, 0, 6), 4'd0, 1);

    repeat (4) @(negedge clk);
    check("R9 access count", n_done, 21);
    check("R9 queue drained", exp_q.size(), 0);
    check("R10 idle at end", busy_o, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule